// File: doc/BRIEF.md
# Port Teardown and Bring-Up Sequencer

This block sits beside a four-port Ethernet MAC. It takes the steps needed to take one port out of service, or to put it back, off the host. A request names a port by a 2-bit index and asks for one of three things:

- a deliberate shutdown,
- a shutdown after the link dropped,
- a bring-up.

The block then issues an ordered series of single-word writes on a simple write bus. Each write holds address, data and strobe until the target acknowledges it. The writes gate the port, clear and reset its transmit FIFO, flush transmit, reset the MAC and reset the receive FIFO. Bring-up undoes the same controls in a set order.

Four control registers are shared by all ports: port enable, MAC soft reset, receive FIFO reset and transmit FIFO reset. In each of them, bit n belongs to port n. The block keeps a shadow copy of these registers, so every write alters only the selected port's bit. Flush is a separate per-port register.

Two waits are timed by a cycle counter:
- A drain wait lets an in-flight frame leave before the flush. It is left out when the link has dropped, since nothing can be sent.
- A settle wait follows bring-up. It is sized from the clock frequency to fall between 1 and 2 µs.

`busy` covers a whole sequence. `done` pulses once at its end.

Top module: `portseq_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `wr_en` are low. All shadow bits are zero: every port is disabled, with no reset or flush asserted. The first write after reset therefore carries only the selected port's bit.
- R2: A shutdown writes, in this order:
  - address 0x500, the port's bit cleared;
  - address 0x620, the port's bit set;
  - address 0x11 + 0x80·port, with data 1;
  - address 0x505, the port's bit set;
  - address 0x59E, the port's bit set.
- R3: In a deliberate shutdown, at least DRAIN_CYCLES clock cycles pass between the acknowledge of the 0x620 write and the acknowledge of the flush write.
- R4: A link-drop request performs the same five writes as R2 but skips the drain wait. The flush write is acknowledged fewer than DRAIN_CYCLES cycles after the 0x620 write.
- R5: A bring-up writes, in this order:
  - address 0x500, the port's bit set;
  - address 0x620, the port's bit cleared;
  - the port's flush address, with data 0;
  - address 0x505, the port's bit cleared;
  - address 0x59E, the port's bit cleared.
- R6: In each shared register (0x500, 0x505, 0x59E, 0x620), bits 3:0 map bit n to port n and all other data bits are zero. A write changes only the selected port's bit. The other three ports' bits keep the values last written to them.
- R7: While `wr_en` is high and `wr_ack` has not been seen, `wr_en`, `wr_addr` and `wr_data` are held unchanged. The sequence moves to its next step only after `wr_ack`.
- R8: After bring-up, `done` rises no sooner than SETTLE_CYCLES = ceil(CLK_MHZ·SETTLE_NS/1000) cycles after the last write's acknowledge. With defaults (250 MHz, 1500 ns) that is 375 cycles. With prompt acknowledges, `done` comes within 2 µs (500 cycles) of the enable write's acknowledge.
- R9: `busy` rises on the cycle after a request is taken and stays high until `done`. Requests that arrive while busy are ignored and cause no writes.
- R10: `done` is a single-cycle pulse and is never high together with `busy`.
- R11: When several requests arrive in the same cycle, link-drop wins over shutdown, and shutdown wins over bring-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_disable | input | 1 | Request a deliberate shutdown of `req_port` |
| req_enable | input | 1 | Request a bring-up of `req_port` |
| req_linkdrop | input | 1 | Request a shutdown after a dropped link (no drain wait) |
| req_port | input | 2 | Port index 0 to 3 |
| wr_addr | output | 12 | Write address |
| wr_data | output | 32 | Write data |
| wr_en | output | 1 | Write strobe, held until acknowledged |
| wr_ack | input | 1 | Write acknowledge from the register target |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
A request taken at one clock edge shows on `busy` after that edge. The first `wr_en` follows one dispatch cycle later. After each acknowledge, the strobe drops for exactly one dispatch cycle before the next write or wait begins.

Because the bench raises `wr_ack` a chosen number of cycles into each write, exact latencies vary. The bench therefore timestamps every acknowledge and the `done` pulse at the falling edge, and checks the waits as bounds between those stamps: at least DRAIN_CYCLES or SETTLE_CYCLES, at most 500 cycles for the settle window, and fewer than DRAIN_CYCLES on link drop. The flag checks are taken one falling edge after the request edge (`busy`) and on every falling edge (`done`).

// File: rtl/portseq_pkg.sv
`timescale 1ns/1ps
package portseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DISPATCH = 2'd1,
        ST_WRITE    = 2'd2,
        ST_WAIT     = 2'd3
    } seq_st_e;

    // One entry of a sequence: a write of one control bit, a timed wait, or the end.
    typedef enum logic [2:0] {
        ACT_EN     = 3'd0,
        ACT_TXR    = 3'd1,
        ACT_FLUSH  = 3'd2,
        ACT_MAC    = 3'd3,
        ACT_RXR    = 3'd4,
        ACT_DRAIN  = 3'd5,
        ACT_SETTLE = 3'd6,
        ACT_END    = 3'd7
    } act_e;

    typedef struct packed {
        act_e act;
        logic val;
    } step_t;

    localparam int STEP_W = 3;

    function automatic logic act_is_write(act_e a);
        return (a == ACT_EN) || (a == ACT_TXR) || (a == ACT_FLUSH) ||
               (a == ACT_MAC) || (a == ACT_RXR);
    endfunction

endpackage

// File: rtl/portseq_steps.sv
`timescale 1ns/1ps
// Fixed step tables for teardown and bring-up. The order is the behaviour.
module portseq_steps
    import portseq_pkg::*;
(
    input  logic              bring_up,
    input  logic              skip_drain,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    logic [STEP_W-1:0] eff;

    always_comb begin
        // On a link drop the drain entry (index 2) is stepped over.
        if (!bring_up && skip_drain && (idx >= STEP_W'(2)))
            eff = idx + STEP_W'(1);
        else
            eff = idx;
    end

    always_comb begin
        step = '{act: ACT_END, val: 1'b0};
        if (bring_up) begin
            case (eff)
                3'd0:    step = '{act: ACT_EN,     val: 1'b1};
                3'd1:    step = '{act: ACT_TXR,    val: 1'b0};
                3'd2:    step = '{act: ACT_FLUSH,  val: 1'b0};
                3'd3:    step = '{act: ACT_MAC,    val: 1'b0};
                3'd4:    step = '{act: ACT_RXR,    val: 1'b0};
                3'd5:    step = '{act: ACT_SETTLE, val: 1'b0};
                default: step = '{act: ACT_END,    val: 1'b0};
            endcase
        end else begin
            case (eff)
                3'd0:    step = '{act: ACT_EN,     val: 1'b0};
                3'd1:    step = '{act: ACT_TXR,    val: 1'b1};
                3'd2:    step = '{act: ACT_DRAIN,  val: 1'b0};
                3'd3:    step = '{act: ACT_FLUSH,  val: 1'b1};
                3'd4:    step = '{act: ACT_MAC,    val: 1'b1};
                3'd5:    step = '{act: ACT_RXR,    val: 1'b1};
                default: step = '{act: ACT_END,    val: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/portseq_timer.sv
`timescale 1ns/1ps
// Down-counter for the drain and settle waits; expired while the count is zero.
module portseq_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R3 / R8: without a load the count never climbs, so a wait cannot stretch.
    assert_count_down_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/portseq_shadow.sv
`timescale 1ns/1ps
// Shadow of the shared per-port control registers, plus write address/data forming.
module portseq_shadow
    import portseq_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int PW          = 2,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int A_EN        = 'h500,
    parameter int A_MAC       = 'h505,
    parameter int A_RXR       = 'h59E,
    parameter int A_TXR       = 'h620,
    parameter int FLUSH_OFS   = 'h11,
    parameter int PORT_STRIDE = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic              val,
    input  logic [PW-1:0]     port,
    input  logic              commit,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    localparam int SH_W = 5 * NPORTS;

    typedef struct packed {
        logic [NPORTS-1:0] en;
        logic [NPORTS-1:0] txr;
        logic [NPORTS-1:0] mac;
        logic [NPORTS-1:0] rxr;
        logic [NPORTS-1:0] flush;
    } shadow_t;

    shadow_t           sh_d, sh_q;
    logic [NPORTS-1:0] cur;
    logic [NPORTS-1:0] img;
    logic [SH_W-1:0]   sh_flat;

    assign sh_flat = sh_q;

    // Select the register image the current action targets and patch one bit.
    always_comb begin
        case (act)
            ACT_EN:    cur = sh_q.en;
            ACT_TXR:   cur = sh_q.txr;
            ACT_MAC:   cur = sh_q.mac;
            ACT_RXR:   cur = sh_q.rxr;
            ACT_FLUSH: cur = sh_q.flush;
            default:   cur = '0;
        endcase
        img       = cur;
        img[port] = val;
    end

    always_comb begin
        addr = '0;
        data = '0;
        case (act)
            ACT_EN:  begin addr = ADDR_W'(A_EN);  data[NPORTS-1:0] = img; end
            ACT_TXR: begin addr = ADDR_W'(A_TXR); data[NPORTS-1:0] = img; end
            ACT_MAC: begin addr = ADDR_W'(A_MAC); data[NPORTS-1:0] = img; end
            ACT_RXR: begin addr = ADDR_W'(A_RXR); data[NPORTS-1:0] = img; end
            ACT_FLUSH: begin
                addr    = ADDR_W'(FLUSH_OFS + int'(port) * PORT_STRIDE);
                data[0] = val;
            end
            default: begin addr = '0; data = '0; end
        endcase
    end

    always_comb begin
        sh_d = sh_q;
        if (commit) begin
            case (act)
                ACT_EN:    sh_d.en    = img;
                ACT_TXR:   sh_d.txr   = img;
                ACT_MAC:   sh_d.mac   = img;
                ACT_RXR:   sh_d.rxr   = img;
                ACT_FLUSH: sh_d.flush = img;
                default:   sh_d       = sh_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    // R6: an acknowledged write moves at most one shadow bit in total.
    assert_single_bit_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(sh_flat ^ $past(sh_flat)) <= 1));

    // R6: without an acknowledged write the shadow holds.
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(sh_flat));

endmodule

// File: rtl/portseq_ctrl.sv
`timescale 1ns/1ps
// Per-port teardown / bring-up sequencer for a four-port MAC.
module portseq_ctrl
    import portseq_pkg::*;
#(
    parameter int NPORTS       = 4,
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int CLK_MHZ      = 250,
    parameter int SETTLE_NS    = 1500,
    parameter int DRAIN_CYCLES = 64,
    parameter int A_EN         = 'h500,
    parameter int A_MAC        = 'h505,
    parameter int A_RXR        = 'h59E,
    parameter int A_TXR        = 'h620,
    parameter int FLUSH_OFS    = 'h11,
    parameter int PORT_STRIDE  = 'h80,
    localparam int PW          = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_disable,
    input  logic              req_enable,
    input  logic              req_linkdrop,
    input  logic [PW-1:0]     req_port,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    input  logic              wr_ack,
    output logic              busy,
    output logic              done
);

    localparam int SETTLE_CYCLES = (CLK_MHZ * SETTLE_NS + 999) / 1000;
    localparam int WAIT_MAX      = (DRAIN_CYCLES > SETTLE_CYCLES) ? DRAIN_CYCLES : SETTLE_CYCLES;
    localparam int CW            = $clog2(WAIT_MAX + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] idx;
        logic [PW-1:0]     port;
        logic              up;
        logic              link;
        logic              busy;
        logic              done;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    step_t         step;
    logic          commit;
    logic          timer_load;
    logic [CW-1:0] timer_val;
    logic          timer_exp;

    portseq_steps u_steps (
        .bring_up   (ctl_q.up),
        .skip_drain (ctl_q.link),
        .idx        (ctl_q.idx),
        .step       (step)
    );

    portseq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (timer_exp)
    );

    portseq_shadow #(
        .NPORTS      (NPORTS),
        .PW          (PW),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .A_EN        (A_EN),
        .A_MAC       (A_MAC),
        .A_RXR       (A_RXR),
        .A_TXR       (A_TXR),
        .FLUSH_OFS   (FLUSH_OFS),
        .PORT_STRIDE (PORT_STRIDE)
    ) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .act    (step.act),
        .val    (step.val),
        .port   (ctl_q.port),
        .commit (commit),
        .addr   (wr_addr),
        .data   (wr_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        commit     = 1'b0;
        timer_load = 1'b0;
        timer_val  = '0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_linkdrop || req_disable || req_enable) begin
                    // Priority: link drop, then shutdown, then bring-up.
                    ctl_d.up   = !req_linkdrop && !req_disable;
                    ctl_d.link = req_linkdrop;
                    ctl_d.port = req_port;
                    ctl_d.idx  = '0;
                    ctl_d.busy = 1'b1;
                    ctl_d.st   = ST_DISPATCH;
                end
            end
            ST_DISPATCH: begin
                if (act_is_write(step.act)) begin
                    ctl_d.st = ST_WRITE;
                end else if (step.act == ACT_DRAIN) begin
                    timer_load = 1'b1;
                    timer_val  = CW'(DRAIN_CYCLES - 1);
                    ctl_d.st   = ST_WAIT;
                end else if (step.act == ACT_SETTLE) begin
                    timer_load = 1'b1;
                    timer_val  = CW'(SETTLE_CYCLES - 1);
                    ctl_d.st   = ST_WAIT;
                end else begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                end
            end
            ST_WRITE: begin
                if (wr_ack) begin
                    commit    = 1'b1;
                    ctl_d.idx = ctl_q.idx + STEP_W'(1);
                    ctl_d.st  = ST_DISPATCH;
                end
            end
            ST_WAIT: begin
                if (timer_exp) begin
                    ctl_d.idx = ctl_q.idx + STEP_W'(1);
                    ctl_d.st  = ST_DISPATCH;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, idx: '0, port: '0, up: 1'b0,
                       link: 1'b0, busy: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_en = (ctl_q.st == ST_WRITE);
    assign busy  = ctl_q.busy;
    assign done  = ctl_q.done;

    // R7: an unacknowledged write keeps its strobe, address and data.
    assert_hold_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_ack) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

    // R10: done lasts one cycle.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done and busy are never high together.
    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: no bus activity outside a sequence.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !wr_en);

    // R9: the selected port cannot be changed by a request during a sequence.
    assert_port_held_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(ctl_q.port)));

    // R4: a link-drop sequence never enters a timed wait.
    assert_link_no_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_WAIT) |-> !ctl_q.link);

endmodule

// File: tb/sim_portseq_ctrl.sv
`timescale 1ns/1ps
module sim_portseq_ctrl;

    localparam int DRAIN  = 40;
    localparam int SETTLE = 375;
    localparam int TWO_US = 500;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_disable = 1'b0, req_enable = 1'b0, req_linkdrop = 1'b0;
    logic [1:0]  req_port = 2'd0;
    logic [11:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_en;
    logic        wr_ack = 1'b0;
    logic        busy, done;

    always #2 clk = ~clk;

    portseq_ctrl #(.DRAIN_CYCLES(DRAIN)) u0 (
        .clk(clk), .rst(rst),
        .req_disable(req_disable), .req_enable(req_enable), .req_linkdrop(req_linkdrop),
        .req_port(req_port),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .wr_ack(wr_ack),
        .busy(busy), .done(done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;

    // Write responder: acknowledges after ack_lat cycles, logs writes and checks holding.
    int          ack_lat = 0, lat_cnt = 0, n_wr = 0, hold_err = 0;
    logic [11:0] la [0:15];
    logic [31:0] ld [0:15];
    int          lc [0:15];
    logic [11:0] hold_a;
    logic [31:0] hold_d;

    always @(negedge clk) begin
        if (wr_ack) begin
            wr_ack  = 1'b0;
            lat_cnt = 0;
        end else if (wr_en) begin
            if (lat_cnt == 0) begin
                hold_a = wr_addr;
                hold_d = wr_data;
            end else if (wr_addr !== hold_a || wr_data !== hold_d) begin
                hold_err++;
            end
            if (lat_cnt >= ack_lat) begin
                wr_ack = 1'b1;
                if (n_wr < 16) begin
                    la[n_wr] = wr_addr;
                    ld[n_wr] = wr_data;
                    lc[n_wr] = cyc;
                end
                n_wr++;
            end else begin
                lat_cnt++;
            end
        end else begin
            if (lat_cnt != 0) hold_err++;   // strobe dropped before acknowledge
            lat_cnt = 0;
        end
    end

    // done monitor
    int   done_cnt = 0, done_cyc = 0, pulse_err = 0;
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (done) begin
            if (prev_done) pulse_err++;
            if (busy) pulse_err++;
            done_cnt++;
            done_cyc = cyc;
        end
        prev_done = done;
    end

    // Reference model of the shared registers, bit n = port n.
    logic [3:0] m_en = '0, m_txr = '0, m_mac = '0, m_rxr = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic dis, input logic en, input logic ldp, input logic [1:0] p);
        @(negedge clk);
        #1;
        n_wr         = 0;
        req_disable  = dis;
        req_enable   = en;
        req_linkdrop = ldp;
        req_port     = p;
        @(negedge clk);
        #1;
        req_disable  = 1'b0;
        req_enable   = 1'b0;
        req_linkdrop = 1'b0;
        chk(busy === 1'b1, "R9 busy after request", busy, 1);
    endtask

    task automatic wait_done();
        int start = done_cnt;
        int t = 0;
        while (done_cnt == start && t < 4000) begin
            @(negedge clk);
            #1;
            t++;
        end
        chk(done_cnt != start, "R9 sequence completes", done_cnt - start, 1);
    endtask

    task automatic compare(input string tag, input logic [11:0] ea [5], input logic [31:0] ed [5]);
        chk(n_wr == 5, {tag, " write count"}, n_wr, 5);
        for (int i = 0; i < 5; i++) begin
            chk(la[i] === ea[i], {tag, " address"}, la[i], ea[i]);
            chk(ld[i] === ed[i], {tag, " data"}, ld[i], ed[i]);
        end
    endtask

    // Teardown: R2 order, R3 drain / R4 skip, R6 other bits, R11 priority.
    task automatic run_disable(input logic [1:0] p, input bit link, input bit all_req,
                               input int lat, input string tag);
        logic [11:0] ea [5];
        logic [31:0] ed [5];
        logic [3:0]  b = 4'(1) << p;
        ack_lat = lat;
        ea[0] = 12'h500; ed[0] = {28'd0, m_en & ~b};
        ea[1] = 12'h620; ed[1] = {28'd0, m_txr | b};
        ea[2] = 12'h011 + 12'(p) * 12'h080; ed[2] = 32'd1;
        ea[3] = 12'h505; ed[3] = {28'd0, m_mac | b};
        ea[4] = 12'h59E; ed[4] = {28'd0, m_rxr | b};
        m_en = m_en & ~b; m_txr = m_txr | b; m_mac = m_mac | b; m_rxr = m_rxr | b;
        if (all_req) issue(1'b1, 1'b1, 1'b1, p);
        else         issue(!link, 1'b0, link, p);
        wait_done();
        compare(tag, ea, ed);
        if (link) chk((lc[2] - lc[1]) < DRAIN, {tag, " R4 drain skipped"}, lc[2] - lc[1], DRAIN);
        else      chk((lc[2] - lc[1]) >= DRAIN, {tag, " R3 drain wait"}, lc[2] - lc[1], DRAIN);
    endtask

    // Bring-up: R5 order, R6 bits, R8 settle; optional intruding request for R9.
    task automatic run_enable(input logic [1:0] p, input int lat, input bit intrude,
                              input string tag);
        logic [11:0] ea [5];
        logic [31:0] ed [5];
        logic [3:0]  b = 4'(1) << p;
        ack_lat = lat;
        ea[0] = 12'h500; ed[0] = {28'd0, m_en | b};
        ea[1] = 12'h620; ed[1] = {28'd0, m_txr & ~b};
        ea[2] = 12'h011 + 12'(p) * 12'h080; ed[2] = 32'd0;
        ea[3] = 12'h505; ed[3] = {28'd0, m_mac & ~b};
        ea[4] = 12'h59E; ed[4] = {28'd0, m_rxr & ~b};
        m_en = m_en | b; m_txr = m_txr & ~b; m_mac = m_mac & ~b; m_rxr = m_rxr & ~b;
        issue(1'b0, 1'b1, 1'b0, p);
        if (intrude) begin
            repeat (10) @(negedge clk);
            #1;
            req_disable = 1'b1; req_port = p + 2'd2;
            @(negedge clk);
            #1;
            req_disable = 1'b0;
        end
        wait_done();
        compare(tag, ea, ed);
        chk((done_cyc - lc[4]) >= SETTLE, {tag, " R8 settle after last write"}, done_cyc - lc[4], SETTLE);
        chk((done_cyc - lc[0]) <= TWO_US, {tag, " R8 settle within 2us"}, done_cyc - lc[0], TWO_US);
        if (intrude) begin
            repeat (20) @(negedge clk);
            #1;
            chk(n_wr == 5, "R9 request while busy ignored", n_wr, 5);
            chk(busy === 1'b0, "R9 idle after ignored request", busy, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(busy === 1'b0, "R1 busy low after reset", busy, 0);
        chk(done === 1'b0, "R1 done low after reset", done, 0);
        chk(wr_en === 1'b0, "R1 wr_en low after reset", wr_en, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        run_enable(2'd2, 0, 1'b0, "R5 R1 enable p2");
        chk(ld[0] === 32'h4, "R1 first write shows only target bit", ld[0], 32'h4);
        run_enable(2'd0, 3, 1'b0, "R5 R7 enable p0 slow ack");
        chk(ld[0] === 32'h5, "R6 port2 bit kept", ld[0], 32'h5);
        run_enable(2'd1, 1, 1'b1, "R5 R9 enable p1 with intrusion");
        run_disable(2'd2, 1'b0, 1'b0, 1, "R2 R6 disable p2");
        run_disable(2'd0, 1'b1, 1'b0, 0, "R4 linkdrop p0");
        run_disable(2'd1, 1'b1, 1'b1, 0, "R11 priority p1");
        run_enable(2'd2, 2, 1'b0, "R5 R6 re-enable p2");
        chk(hold_err == 0, "R7 write held until acknowledge", hold_err, 0);
        chk(pulse_err == 0, "R10 done single pulse, not with busy", pulse_err, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule